// File: doc/BRIEF.md
# Four-Channel Converter Write Decoder

This block sits between an 8-bit processor write bus and four double-buffered 12-bit converter channels. Each channel has two input registers, a low byte and a high nibble. A shared output rank copies those registers into the converter. The block decodes the low address bits of a bus write, together with an active-low chip-select and an active-low write strobe. From these it drives active-low enables for each channel's low-byte and high-nibble registers, a shared output-load enable, and a gated copy of the write strobe. It also spreads the 8-bit bus onto a right-justified 12-bit code bus that feeds every channel.

A mode input picks one of two address maps. In the four-channel map, each channel owns two adjacent addresses, and a broadcast address moves every channel's input registers into its output rank at the same moment. In the single-channel map, only channel 0 is served. There, loading the high nibble also transfers both registers to the output rank in the same strobe, which saves one bus write per update. The decoder is purely combinational: every enable follows the bus strobe directly.

Top module: `dac_bus_decoder`

## Requirements
- R1: While chip-select (csN) or the write strobe (wrN) is high, every enable output and wrOutN are high (inactive).
- R2: In four-channel mode (modeSingle=0), a write to an address with bit 3 clear and bit 0 = 0 drives low only loByteN[k], where k = address bits 2:1.
- R3: In four-channel mode, a write to an address with bit 3 clear and bit 0 = 1 drives low only hiNibN[k], where k = address bits 2:1.
- R4: In four-channel mode, a write to any address with bit 3 set drives low loadOutN and no per-channel enable, whatever the values of address bits 2:0. Every channel's output rank then updates in the same strobe.
- R5: In four-channel mode, loadOutN stays high for every address with bit 3 clear.
- R6: codeBus[11:8] equals busData[3:0] and codeBus[7:0] equals busData[7:0] at all times.
- R7: In single-channel mode (modeSingle=1), address bits 1:0 = 2'b10 drive low only loByteN[0].
- R8: In single-channel mode, address bits 1:0 = 2'b01 drive low hiNibN[0] and loadOutN together, and no other enable.
- R9: In single-channel mode, address bits 1:0 = 2'b00 or 2'b11 drive no enable. Address bits 3:2 have no effect in this mode.
- R10: wrOutN is low exactly when csN and wrN are both low.
- R11: At most one of the eight per-channel enables is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csN | input | 1 | Chip-select from the base-address decoder, active low |
| wrN | input | 1 | Processor write strobe, active low |
| modeSingle | input | 1 | 0 = four-channel map with broadcast load, 1 = single-channel combined-transfer map |
| addr | input | 4 | Low address bits of the write |
| busData | input | 8 | Processor write data |
| loByteN | output | 4 | Per-channel low-byte register enable, active low |
| hiNibN | output | 4 | Per-channel high-nibble register enable, active low |
| loadOutN | output | 1 | Shared output-rank load enable, active low |
| wrOutN | output | 1 | Gated write strobe to all channels, active low |
| codeBus | output | 12 | Right-justified code bus shared by all channels |

## Verification
The bench sweeps all eight per-channel addresses in four-channel mode, each with a different data byte. A swapped channel index, a swapped section bit or a misrouted nibble shows up in a different enable or code bit. The broadcast is tried at the lowest and highest bit-3 addresses and at one address in between, to show that bits 2:0 are ignored. A bench model of the four channels confirms that all four output ranks take their new codes in the same strobe, while the enables before the broadcast never touch an output rank. In single-channel mode, all four values of address bits 1:0 are applied, and some are repeated with bits 3:2 set. This separates the combined transfer from the ignored codes and shows that the upper bits have no effect. Writes with chip-select high and the strobe low confirm that no enable escapes.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  parameter int unsigned WDEC_CH = 4;

  typedef struct packed {
    logic [WDEC_CH-1:0] loSel;
    logic [WDEC_CH-1:0] hiSel;
    logic               loadAll;
    logic               wrPass;
  } wdecStrobe_t;
endpackage

// File: rtl/wdec_ctrl.sv
module wdec_ctrl
  import wdec_pkg::*;
#(
  parameter int unsigned NUM_CH  = WDEC_CH,
  parameter int unsigned CH_BITS = $clog2(NUM_CH),
  parameter int unsigned ADDR_W  = CH_BITS + 2
) (
  input  logic              csN,
  input  logic              wrN,
  input  logic              modeSingle,
  input  logic [ADDR_W-1:0] addr,
  output wdecStrobe_t       stb
);
  localparam int unsigned BCAST_BIT = ADDR_W - 1;

  logic               active;
  logic               multiOk;
  logic               singleOk;
  logic [CH_BITS-1:0] chanIdx;
  logic               secHi;
  logic               bcast;
  logic               singleLo;
  logic               singleHi;

  always_comb begin
    active   = !csN && !wrN;
    multiOk  = active && !modeSingle;
    singleOk = active && modeSingle;
    chanIdx  = addr[CH_BITS:1];
    secHi    = addr[0];
    bcast    = addr[BCAST_BIT];
    singleLo = (addr[1:0] == 2'b10);
    singleHi = (addr[1:0] == 2'b01);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hitChan;
    assign hitChan = multiOk && !bcast && (chanIdx == CH_BITS'(ch));
    if (ch == 0) begin : g_first
      assign stb.loSel[ch] = (hitChan && !secHi) || (singleOk && singleLo);
      assign stb.hiSel[ch] = (hitChan &&  secHi) || (singleOk && singleHi);
    end else begin : g_rest
      assign stb.loSel[ch] = hitChan && !secHi;
      assign stb.hiSel[ch] = hitChan &&  secHi;
    end
  end

  assign stb.loadAll = (multiOk && bcast) || (singleOk && singleHi);
  assign stb.wrPass  = active;

  always_comb begin
    if (!$isunknown({stb, csN, wrN})) begin
      // R11
      one_sel_chk: assert ($countones({stb.loSel, stb.hiSel}) <= 1)
        else $error("more than one channel enable selected");
      // R1
      idle_quiet_chk: assert (!(csN || wrN) || ({stb.loSel, stb.hiSel, stb.loadAll} == '0))
        else $error("select raised while bus idle");
    end
  end
endmodule

// File: rtl/wdec_data.sv
module wdec_data
  import wdec_pkg::*;
#(
  parameter int unsigned NUM_CH = WDEC_CH,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CODE_W = 12
) (
  input  wdecStrobe_t        stb,
  input  logic [BUS_W-1:0]   busData,
  output logic [NUM_CH-1:0]  loByteN,
  output logic [NUM_CH-1:0]  hiNibN,
  output logic               loadOutN,
  output logic               wrOutN,
  output logic [CODE_W-1:0]  codeBus
);
  localparam int unsigned HI_W = CODE_W - BUS_W;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_drv
    assign loByteN[ch] = !stb.loSel[ch];
    assign hiNibN[ch]  = !stb.hiSel[ch];
  end

  assign loadOutN = !stb.loadAll;
  assign wrOutN   = !stb.wrPass;
  assign codeBus  = {busData[HI_W-1:0], busData};

  always_comb begin
    if (!$isunknown({loByteN, hiNibN, loadOutN, wrOutN})) begin
      // R10
      strobe_cover_chk: assert (((&loByteN) && (&hiNibN) && loadOutN) || !wrOutN)
        else $error("enable driven without write strobe");
    end
  end
endmodule

// File: rtl/dac_bus_decoder.sv
module dac_bus_decoder
  import wdec_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CODE_W = 12
) (
  input  logic              csN,
  input  logic              wrN,
  input  logic              modeSingle,
  input  logic [3:0]        addr,
  input  logic [BUS_W-1:0]  busData,
  output logic [3:0]        loByteN,
  output logic [3:0]        hiNibN,
  output logic              loadOutN,
  output logic              wrOutN,
  output logic [CODE_W-1:0] codeBus
);
  localparam int unsigned NUM_CH  = WDEC_CH;
  localparam int unsigned CH_BITS = $clog2(NUM_CH);
  localparam int unsigned ADDR_W  = CH_BITS + 2;

  wdecStrobe_t stb;

  wdec_ctrl #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W)) u_ctrl (
    .csN(csN), .wrN(wrN), .modeSingle(modeSingle), .addr(addr), .stb(stb)
  );

  wdec_data #(.NUM_CH(NUM_CH), .BUS_W(BUS_W), .CODE_W(CODE_W)) u_data (
    .stb(stb), .busData(busData), .loByteN(loByteN), .hiNibN(hiNibN),
    .loadOutN(loadOutN), .wrOutN(wrOutN), .codeBus(codeBus)
  );

  always_comb begin
    if (!$isunknown({modeSingle, addr, loByteN, hiNibN, loadOutN})) begin
      // R4
      bcast_excl_chk: assert (modeSingle || loadOutN || ((&loByteN) && (&hiNibN)))
        else $error("channel enable during broadcast load");
      // R8
      combined_chk: assert (!modeSingle || hiNibN[0] || !loadOutN)
        else $error("high nibble load without output transfer");
    end
  end
endmodule

// File: tb/sim_dac_bus_decoder.sv
module sim_dac_bus_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        csN, wrN, modeSingle;
  logic [3:0]  addr;
  logic [7:0]  busData;
  logic [3:0]  loByteN, hiNibN;
  logic        loadOutN, wrOutN;
  logic [11:0] codeBus;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0]  mLo  [4];
  logic [3:0]  mHi  [4];
  logic [11:0] mOut [4];

  dac_bus_decoder u0 (
    .csN(csN), .wrN(wrN), .modeSingle(modeSingle), .addr(addr), .busData(busData),
    .loByteN(loByteN), .hiNibN(hiNibN), .loadOutN(loadOutN), .wrOutN(wrOutN),
    .codeBus(codeBus)
  );

  // Expected {loByteN, hiNibN, loadOutN, wrOutN, codeBus} from the requirements.
  function automatic logic [21:0] expect_out(input logic m, input logic [3:0] a,
                                             input logic [7:0] d, input logic cs,
                                             input logic wr);
    logic [3:0] lo = 4'hF, hi = 4'hF;
    logic ld = 1'b1, w = 1'b1;
    if (!cs && !wr) begin
      w = 1'b0;
      if (!m) begin
        if (a[3]) ld = 1'b0;
        else if (a[0]) hi[a[2:1]] = 1'b0;
        else lo[a[2:1]] = 1'b0;
      end else begin
        if (a[1:0] == 2'b10) lo[0] = 1'b0;
        if (a[1:0] == 2'b01) begin hi[0] = 1'b0; ld = 1'b0; end
      end
    end
    return {lo, hi, ld, w, d[3:0], d};
  endfunction

  task automatic check(input string tag, input logic [21:0] act, input logic [21:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input string tag, input logic m, input logic [3:0] a,
                          input logic [7:0] d, input logic cs);
    @(negedge clk);
    modeSingle = m; addr = a; busData = d; csN = cs; wrN = 1'b1;
    @(negedge clk);
    wrN = 1'b0;
    #2;
    check(tag, {loByteN, hiNibN, loadOutN, wrOutN, codeBus}, expect_out(m, a, d, cs, 1'b0));
    for (int k = 0; k < 4; k++) begin
      if (!loByteN[k]) mLo[k] = codeBus[7:0];
      if (!hiNibN[k])  mHi[k] = codeBus[11:8];
    end
    if (!loadOutN)
      for (int k = 0; k < 4; k++) mOut[k] = {mHi[k], mLo[k]};
    @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
    #2;
    check({tag, " release R1"}, {loByteN, hiNibN, loadOutN, wrOutN, codeBus},
          expect_out(m, a, d, 1'b1, 1'b1));
  endtask

  task automatic check_outs(input string tag, input logic [11:0] e0, input logic [11:0] e1,
                            input logic [11:0] e2, input logic [11:0] e3);
    check(tag, {10'd0, mOut[0]}, {10'd0, e0});
    check(tag, {10'd0, mOut[1]}, {10'd0, e1});
    check(tag, {10'd0, mOut[2]}, {10'd0, e2});
    check(tag, {10'd0, mOut[3]}, {10'd0, e3});
  endtask

  task automatic test_idle();
    #2;
    check("R1 idle", {loByteN, hiNibN, loadOutN, wrOutN, codeBus},
          expect_out(1'b0, 4'h0, 8'h00, 1'b1, 1'b1));
    do_write("R1 cs inactive", 1'b0, 4'h0, 8'h5A, 1'b1);
    do_write("R1 cs inactive bcast", 1'b0, 4'h8, 8'hA5, 1'b1);
    do_write("R10 cs inactive single", 1'b1, 4'h1, 8'h3C, 1'b1);
  endtask

  task automatic test_multi();
    do_write("R2 ch0 lo", 1'b0, 4'h0, 8'h12, 1'b0);
    do_write("R3 ch0 hi", 1'b0, 4'h1, 8'hF1, 1'b0);
    do_write("R2 ch1 lo", 1'b0, 4'h2, 8'h34, 1'b0);
    do_write("R3 ch1 hi", 1'b0, 4'h3, 8'h02, 1'b0);
    do_write("R2 ch2 lo", 1'b0, 4'h4, 8'h56, 1'b0);
    do_write("R3 ch2 hi", 1'b0, 4'h5, 8'hA3, 1'b0);
    do_write("R6 ch3 lo", 1'b0, 4'h6, 8'hFF, 1'b0);
    do_write("R5 ch3 hi", 1'b0, 4'h7, 8'h04, 1'b0);
    check_outs("R5 no transfer before bcast", 12'h000, 12'h000, 12'h000, 12'h000);
    do_write("R4 bcast 8", 1'b0, 4'h8, 8'h00, 1'b0);
    check_outs("R4 all ranks updated", 12'h112, 12'h234, 12'h356, 12'h4FF);
    do_write("R2 ch2 lo again", 1'b0, 4'h4, 8'h9E, 1'b0);
    check_outs("R5 rank holds", 12'h112, 12'h234, 12'h356, 12'h4FF);
    do_write("R4 bcast F", 1'b0, 4'hF, 8'h77, 1'b0);
    check_outs("R4 bcast F ranks", 12'h112, 12'h234, 12'h39E, 12'h4FF);
    do_write("R4 bcast B", 1'b0, 4'hB, 8'h81, 1'b0);
  endtask

  task automatic test_single();
    do_write("R7 single lo", 1'b1, 4'h2, 8'hC3, 1'b0);
    do_write("R9 single 00", 1'b1, 4'h0, 8'h11, 1'b0);
    do_write("R9 single 11", 1'b1, 4'h3, 8'h22, 1'b0);
    check_outs("R9 ignored codes", 12'h112, 12'h234, 12'h39E, 12'h4FF);
    do_write("R8 single hi+load", 1'b1, 4'h1, 8'h0B, 1'b0);
    check({"R8 ch0 rank"}, {10'd0, mOut[0]}, {10'd0, 12'hBC3});
    do_write("R9 upper bits lo", 1'b1, 4'hE, 8'h6D, 1'b0);
    do_write("R9 upper bits hi", 1'b1, 4'hD, 8'h05, 1'b0);
    check({"R9 ch0 rank upper"}, {10'd0, mOut[0]}, {10'd0, 12'h56D});
    do_write("R9 upper bits 00", 1'b1, 4'hC, 8'hEE, 1'b0);
  endtask

  initial begin
    csN = 1'b1; wrN = 1'b1; modeSingle = 1'b0; addr = '0; busData = '0;
    for (int k = 0; k < 4; k++) begin mLo[k] = '0; mHi[k] = '0; mOut[k] = '0; end
    repeat (2) @(negedge clk);
    test_idle();
    test_multi();
    test_single();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule